// File: doc/BRIEF.md
# Strobe-Framed Serial Register Port

This block lets an external host read and write a bank of 8-bit registers over a fast, clocked serial link that has no chip select. The host presents two bits on every rising edge of the link clock. A transaction is 18 bits long, so it takes nine clocks: first the data byte, then the address byte, and last a 2-bit command. A separate strobe input is high only during the clock that carries the command bits. That strobe is the only thing that marks the end of a transaction.

There is no bit counter. The port shifts on every rising edge and decodes whatever the newest 18 bits hold when it samples the strobe high, so any stray clock edges between transactions do no harm. On every edge the address byte sitting in the shifter already drives the register read multiplexer. The read word is therefore ready when the strobe arrives. The first read bit leaves on the falling edge immediately after the strobe edge, which leaves only half a clock period for it. The remaining bits follow one full period apart, MSB first, on a single output line.

Top module: `serial_reg_port`

## Requirements
- R1: On every rising clock edge the port takes in both input lanes, with `sdi[1]` treated as the earlier bit of the pair, so an 18-bit transaction goes in as nine pairs with the first bit sent on `sdi[1]` of the first clock.
- R2: Shifting never pauses. When the strobe is sampled high, the newest 18 received bits are decoded as data (oldest 8 bits, MSB first), then address (next 8, MSB first), then command (the 2 bits of the strobe clock, `sdi[1]` as command bit 1). Any number of extra clocks before a transaction have no effect on its result.
- R3: Command 2'b01 writes the data byte into the addressed register on the rising edge that samples the strobe.
- R4: Command 2'b10 sends the addressed register out on `sdo`, MSB first. The first bit appears on the falling edge right after the strobe edge and each following bit one clock later, for 8 bits in all.
- R5: `sdo` is 0 whenever no read is in progress, including from the falling edge after the eighth read bit onward.
- R6: Commands 2'b00 and 2'b11 change no register.
- R7: A read returns the register contents as they stand at the strobe edge, including every earlier write, for any of the 256 addresses.
- R8: An asynchronous active-low reset clears every register to 0, empties the shifter and holds `sdo` at 0.
- R9: A strobe that arrives while a read is still sending ends that read at once. A new read restarts the output with the new word on the next falling edge. Any other command leaves `sdo` at 0 from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial link clock; inputs sampled on rising edge, output driven on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 2 | Serial input lanes; bit 1 carries the earlier bit of each pair |
| strobe | input | 1 | High during the clock carrying the command bits |
| sdo | output | 1 | Serial read data, MSB first |

## Verification
On every cycle, assertions check the following: the shifter ages its contents by one lane pair per edge; a write lands in the addressed register; a non-writing cycle leaves the addressed entry alone; the bit budget is loaded on a read strobe and cleared by any other strobe; the budget counts down by one per edge; and `sdo` stays low whenever no bits remain. Only the bench's scenarios can show the rest. That covers the mapping of lanes and fields to the host's bit order, and reading back earlier writes across many addresses. It also covers the exact falling edge on which each bit appears, tolerance of stray clocks before a transaction, and the behaviour when a strobe cuts a read short or reset strikes in the middle of traffic.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int CMD_W = 2;

    typedef enum logic [CMD_W-1:0] {
        OP_IDLE_LO = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_IDLE_HI = 2'b11
    } op_e;

endpackage

// File: rtl/sreg_shifter.sv
module sreg_shifter
    import sreg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] sdi,
    input  logic              strobe,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [DATA_W-1:0] fr_data,
    output logic              fr_write,
    output logic              fr_read,
    output logic              fr_other
);

    localparam int HIST_W = DATA_W + ADDR_W + CMD_W;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } shf_t;

    shf_t              st_d, st_q;
    logic [HIST_W-1:0] frame;
    op_e               op;

    always_comb begin
        frame     = {st_q.hist[HIST_W-LANE_W-1:0], sdi};
        st_d.hist = frame;
        op        = op_e'(frame[CMD_W-1:0]);
        fr_data   = frame[CMD_W+ADDR_W +: DATA_W];
        fr_write  = strobe && (op == OP_WRITE);
        fr_read   = strobe && (op == OP_READ);
        fr_other  = strobe && (op != OP_READ);
    end

    // Prefetch path: when the command fits in one clock, the address is
    // fully held by the register and the read mux settles a whole period early.
    generate
        if (CMD_W == LANE_W) begin : g_fast_pf
            assign pf_addr = st_q.hist[ADDR_W-1:0];
        end else begin : g_slow_pf
            assign pf_addr = frame[CMD_W +: ADDR_W];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: each edge ages the previous pair by one lane slot
    a_r1_pair_ages: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hist[2*LANE_W-1:LANE_W] == $past(st_q.hist[LANE_W-1:0]));

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[addr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[addr];

    // R3: a write is visible at its address one edge later
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(addr)] == $past(wdata));

    // R6: without a write the addressed entry keeps its value
    a_r6_entry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> mem_q[$past(addr)] == $past(rdata));

endmodule

// File: rtl/sreg_serializer.sv
module sreg_serializer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              stop,
    input  logic [DATA_W-1:0] word,
    output logic              sdo
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    typedef struct packed {
        logic [CNT_W-1:0]  left;
        logic [DATA_W-1:0] sr;
    } ser_t;

    ser_t st_d, st_q;
    logic sdo_d, sdo_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.left = FULL;
            st_d.sr   = word;
        end else if (stop) begin
            st_d.left = '0;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
            st_d.sr   = {st_q.sr[DATA_W-2:0], 1'b0};
        end
        sdo_d = (st_q.left != '0) ? st_q.sr[DATA_W-1] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Output launched half a period after the strobe edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sdo_q <= 1'b0;
        else        sdo_q <= sdo_d;
    end

    assign sdo = sdo_q;

    // R4: a read strobe arms a full word
    a_r4_arm_full: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> st_q.left == FULL);

    // R4: one bit consumed per clock while sending
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !stop && st_q.left != '0) |=> st_q.left == $past(st_q.left) - 1'b1);

    // R4: budget never exceeds one word
    a_r4_budget_cap: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left <= FULL);

    // R9: a non-read strobe ends any read in flight
    a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> st_q.left == '0);

    // R5: line is low whenever nothing remains to send
    a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.left == '0) |-> !sdo_q);

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import sreg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] sdi,
    input  logic              strobe,
    output logic              sdo
);

    logic [ADDR_W-1:0] pf_addr;
    logic [DATA_W-1:0] fr_data;
    logic [DATA_W-1:0] rd_word;
    logic              fr_write;
    logic              fr_read;
    logic              fr_other;

    sreg_shifter #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sdi      (sdi),
        .strobe   (strobe),
        .pf_addr  (pf_addr),
        .fr_data  (fr_data),
        .fr_write (fr_write),
        .fr_read  (fr_read),
        .fr_other (fr_other)
    );

    sreg_bank #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fr_write),
        .addr  (pf_addr),
        .wdata (fr_data),
        .rdata (rd_word)
    );

    sreg_serializer #(
        .DATA_W (DATA_W)
    ) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fr_read),
        .stop  (fr_other),
        .word  (rd_word),
        .sdo   (sdo)
    );

    // R2: a strobe decodes to exactly one kind of action
    a_r2_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fr_write, fr_read}));

endmodule

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sdi = 2'b00;
    logic       strobe = 1'b0;
    logic       sdo;

    always #2 clk = ~clk;

    serial_reg_port uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sdi    (sdi),
        .strobe (strobe),
        .sdo    (sdo)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string tag = "R5";

    // Behavioural reference
    logic [7:0] ref_mem [256];
    bit         hist[$];
    bit         outq[$];
    bit         exp_bit;
    bit         exp_is_read;

    task automatic ref_reset();
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        hist.delete();
        for (int i = 0; i < 18; i++) hist.push_back(1'b0);
        outq.delete();
    endtask

    task automatic ref_rise(input logic [1:0] d, input logic s);
        logic [7:0] a, v, rv;
        logic [1:0] c;
        hist.push_back(d[1]);
        hist.push_back(d[0]);
        while (hist.size() > 18) void'(hist.pop_front());
        if (s) begin
            for (int i = 0; i < 8; i++) begin
                v[7-i] = hist[i];
                a[7-i] = hist[8+i];
            end
            c  = {hist[16], hist[17]};
            rv = ref_mem[a];
            outq.delete();
            if (c == 2'b01) ref_mem[a] = v;
            if (c == 2'b10) for (int i = 7; i >= 0; i--) outq.push_back(rv[i]);
        end
    endtask

    task automatic ref_fall();
        if (outq.size() != 0) begin
            exp_bit     = outq.pop_front();
            exp_is_read = 1'b1;
        end else begin
            exp_bit     = 1'b0;
            exp_is_read = 1'b0;
        end
    endtask

    task automatic check(input string req, input logic act, input logic expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s at %0t: sdo=%b expected %b", req, $time, act, expv);
        end
    endtask

    // One clock: drive, rising edge, falling edge, compare after the fall
    task automatic step(input logic [1:0] d, input logic s);
        sdi    = d;
        strobe = s;
        @(posedge clk);
        ref_rise(d, s);
        @(negedge clk);
        ref_fall();
        #1;
        check(exp_is_read ? tag : "R5", sdo, exp_bit);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(2'($urandom_range(0, 3)), 1'b0);
    endtask

    task automatic xact(input logic [7:0] dv, input logic [7:0] av,
                        input logic [1:0] cv, input int extra);
        logic [17:0] fr;
        idle(extra);
        fr = {dv, av, cv};
        for (int k = 0; k < 9; k++) step(fr[17-2*k -: 2], k == 8);
    endtask

    task automatic hard_reset();
        rst_n = 1'b0;
        ref_reset();
        #1;
        check("R8", sdo, 1'b0);
        repeat (2) @(negedge clk);
        check("R8", sdo, 1'b0);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        ref_reset();
        repeat (3) @(negedge clk);
        check("R8", sdo, 1'b0);
        rst_n = 1'b1;
        #1;

        // R8: everything reads zero after reset
        tag = "R5"; idle(3);
        tag = "R8"; xact(8'h00, 8'h55, 2'b10, 0); idle(10);

        // R1: lane order via an asymmetric pattern
        tag = "R1";
        xact(8'hB1, 8'h2D, 2'b01, 0);
        xact(8'h00, 8'h2D, 2'b10, 0); idle(10);

        // R3 / R4: write then read, MSB first on consecutive falling edges
        tag = "R3";
        xact(8'hA5, 8'h3C, 2'b01, 0);
        xact(8'h00, 8'h3C, 2'b10, 0); idle(10);
        tag = "R4";
        xact(8'h81, 8'hFF, 2'b01, 1);
        xact(8'h00, 8'hFF, 2'b10, 0); idle(10);

        // R2: stray clocks before transactions
        tag = "R2";
        xact(8'h5A, 8'h80, 2'b01, 5);
        xact(8'h00, 8'h80, 2'b10, 7); idle(10);

        // R6: idle commands leave the register alone
        tag = "R6";
        xact(8'hFF, 8'h3C, 2'b00, 2);
        xact(8'h0F, 8'h3C, 2'b11, 0);
        xact(8'h00, 8'h3C, 2'b10, 0); idle(10);

        // R7: back-to-back write and read
        tag = "R7";
        xact(8'h6E, 8'h01, 2'b01, 0);
        xact(8'h00, 8'h01, 2'b10, 0);
        xact(8'hC3, 8'hFE, 2'b01, 0);
        xact(8'h00, 8'hFE, 2'b10, 0); idle(10);

        // R9: strobe during a read
        tag = "R9";
        xact(8'h00, 8'h3C, 2'b10, 0);
        step(2'b11, 1'b0); step(2'b00, 1'b0); step(2'b10, 1'b1);
        idle(10);
        xact(8'h00, 8'h80, 2'b10, 0);
        step(2'b01, 1'b0); step(2'b01, 1'b1);
        idle(6);
        xact(8'h00, 8'h2D, 2'b10, 0);
        step(2'b00, 1'b0); step(2'b00, 1'b0); step(2'b11, 1'b1);
        idle(8);

        // R7: random traffic over a small address window
        tag = "R7";
        for (int t = 0; t < 400; t++) begin
            logic [1:0] c;
            c = (t % 3 == 0) ? 2'($urandom_range(0, 3)) : ((t % 2 == 0) ? 2'b01 : 2'b10);
            xact(8'($urandom_range(0, 255)), 8'($urandom_range(0, 15)), c,
                 $urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) idle(8);
        end
        idle(10);

        // R8: reset in the middle of traffic clears written registers
        xact(8'hEE, 8'h07, 2'b01, 0);
        xact(8'h00, 8'h07, 2'b10, 0);
        step(2'b01, 1'b0);
        hard_reset();
        tag = "R8";
        idle(2);
        xact(8'h00, 8'h07, 2'b10, 0); idle(10);
        xact(8'h00, 8'h3C, 2'b10, 0); idle(10);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule